// File: doc/BRIEF.md
# Bit-Split Multi-Pattern Rule Module

This block searches a streaming payload, one byte per clock, for up to sixteen byte strings at once. A string may start at any byte offset, and the stream is read exactly once. The byte is split into four 2-bit fields. Each field drives its own small automaton, called a tile. A tile holds a programmable state table. On every valid byte, each tile moves to its next state and gives the partial match vector of the state it reached. The block ANDs the four partial vectors bit by bit and registers the result as a 16-bit full match vector. Bit j of that vector reports that string j of the group ends at the current byte.

Software that is not part of this block compiles a string group into four state tables. It loads them row by row through the configuration port. The port selects the tile, the row (state) address and the row word. A restart input sends every tile back to state 0 between packets. For larger rule sets, several instances sit side by side on the same byte stream. Their match vectors are concatenated, so each bit position names one string across all groups.

Top module: `strmatch_rule_module`

## Requirements
- R1: Tile t (t = 0..3) receives byte bits [2t+1:2t]: tile 0 takes bits [1:0], tile 1 bits [3:2], tile 2 bits [5:4] and tile 3 bits [7:6]. All four tiles step on the same byte in the same cycle.
- R2: A table row is 32 bits. Bits [15:0] hold the partial match vector of that state. Bits [16+4f+3:16+4f] hold the next state for 2-bit field value f. On a valid byte, a tile moves to the next state that its current row lists for its field. Its partial vector becomes bits [15:0] of the row of the state it reached.
- R3: Bit j of the full match vector is set only when bit j is set in the partial vectors of all four tiles. A bit set in fewer than four tiles never produces a match.
- R4: match_valid is high exactly two cycles after the cycle in which byte_valid was sampled high. It is low otherwise. match_vec is all zero whenever match_valid is low.
- R5: In a cycle without byte_valid, no tile state changes unless pkt_restart is high. A gap in the stream therefore has no effect on later matches.
- R6: pkt_restart returns every tile to state 0. If byte_valid is high in the same cycle, that byte is processed starting from state 0.
- R7: A configuration write (cfg_we) replaces only row cfg_addr of tile cfg_tile. A byte looked up in the same cycle still sees the old contents of that row.
- R8: Reset clears all table rows to zero and all states to 0. Until tables are loaded, every valid byte yields an all-zero match vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | byte_data carries a payload byte this cycle |
| byte_data | input | 8 | Payload byte |
| pkt_restart | input | 1 | Return all tiles to state 0 |
| cfg_we | input | 1 | Table row write strobe |
| cfg_tile | input | 2 | Tile receiving the write |
| cfg_addr | input | 4 | Row (state) address of the write |
| cfg_row | input | 32 | Row word: next states in [31:16], partial vector in [15:0] |
| match_valid | output | 1 | match_vec is valid for the byte taken two cycles earlier |
| match_vec | output | 16 | Full match vector, one bit per string |

## Verification
A wrong state in any single tile usually does not appear at once. Any tile that has drifted returns its partial vectors from the wrong rows, so the AND clears or sets bits two cycles after the faulty step. The error then persists until a restart. The bench therefore loads dense, sparse and single-tile tables. It compares every output cycle with a bench-side model of the four automata, so that one missing or extra state step shows up within a few bytes. Gaps, restarts and same-cycle writes are mixed into the stream so that timing faults in hold, restart and write ordering show up as mismatched vectors right away.

// File: rtl/strmatch_pkg.sv
package strmatch_pkg;
    localparam int BYTE_W     = 8;
    localparam int FIELD_W    = 2;
    localparam int NUM_TILES  = BYTE_W / FIELD_W;
    localparam int FIELD_VALS = 1 << FIELD_W;
    localparam int TILE_SEL_W = $clog2(NUM_TILES);
endpackage

// File: rtl/strmatch_tile.sv
module strmatch_tile
    import strmatch_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int PMV_W   = 16,
    parameter int ROW_W   = PMV_W + FIELD_VALS * STATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               in_valid_i,
    input  logic               restart_i,
    input  logic               wr_en_i,
    input  logic [STATE_W-1:0] wr_addr_i,
    input  logic [ROW_W-1:0]   wr_row_i,
    output logic [PMV_W-1:0]   pmv_o
);
    localparam int NUM_STATES = 1 << STATE_W;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [PMV_W-1:0]   pmv;
    } tile_regs_t;

    tile_regs_t       r_d, r_q;
    logic [ROW_W-1:0] table_d [NUM_STATES];
    logic [ROW_W-1:0] table_q [NUM_STATES];

    logic [STATE_W-1:0] base_state, hop_state;
    logic [ROW_W-1:0]   base_row, hop_row;

    always_comb begin
        table_d = table_q;
        if (wr_en_i) begin
            table_d[wr_addr_i] = wr_row_i;
        end

        base_state = restart_i ? '0 : r_q.state;
        base_row   = table_q[base_state];
        hop_state  = base_row[PMV_W + int'(field_i) * STATE_W +: STATE_W];
        hop_row    = table_q[hop_state];

        r_d = r_q;
        if (in_valid_i) begin
            r_d.state = hop_state;
            r_d.pmv   = hop_row[PMV_W-1:0];
        end else if (restart_i) begin
            r_d.state = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < NUM_STATES; i++) begin
                table_q[i] <= '0;
            end
        end else begin
            r_q     <= r_d;
            table_q <= table_d;
        end
    end

    assign pmv_o = r_q.pmv;

    // R5: an idle cycle leaves the partial vector untouched
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid_i && !restart_i) |=> (r_q.state == $past(r_q.state)) && $stable(pmv_o));

    // R6: restart without a byte lands in state 0
    assert_restart_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !in_valid_i) |=> (r_q.state == '0));

    // R7: a written row holds the written word afterwards
    assert_row_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (table_q[$past(wr_addr_i)] == $past(wr_row_i)));
endmodule

// File: rtl/strmatch_and_stage.sv
module strmatch_and_stage
    import strmatch_pkg::*;
#(
    parameter int PMV_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid_i,
    input  logic [NUM_TILES-1:0][PMV_W-1:0]     pmv_i,
    output logic                                match_valid_o,
    output logic [PMV_W-1:0]                    match_vec_o
);
    typedef struct packed {
        logic             v1;
        logic             mv;
        logic [PMV_W-1:0] vec;
    } stage_regs_t;

    stage_regs_t      s_d, s_q;
    logic [PMV_W-1:0] agree;

    always_comb begin
        agree = '1;
        for (int t = 0; t < NUM_TILES; t++) begin
            agree &= pmv_i[t];
        end
        s_d     = s_q;
        s_d.v1  = in_valid_i;
        s_d.mv  = s_q.v1;
        s_d.vec = s_q.v1 ? agree : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign match_valid_o = s_q.mv;
    assign match_vec_o   = s_q.vec;

    // R3: every reported bit was flagged by each tile
    for (genvar t = 0; t < NUM_TILES; t++) begin : g_subset
        assert_tile_agrees_R3: assert property (@(posedge clk) disable iff (!rst_n)
            match_valid_o |-> ((match_vec_o & ~$past(pmv_i[t])) == '0));
    end
endmodule

// File: rtl/strmatch_rule_module.sv
module strmatch_rule_module
    import strmatch_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int PMV_W   = 16,
    parameter int ROW_W   = PMV_W + FIELD_VALS * STATE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_valid,
    input  logic [BYTE_W-1:0]     byte_data,
    input  logic                  pkt_restart,
    input  logic                  cfg_we,
    input  logic [TILE_SEL_W-1:0] cfg_tile,
    input  logic [STATE_W-1:0]    cfg_addr,
    input  logic [ROW_W-1:0]      cfg_row,
    output logic                  match_valid,
    output logic [PMV_W-1:0]      match_vec
);
    logic [NUM_TILES-1:0][PMV_W-1:0] pmv_all;

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        logic wr_sel;
        assign wr_sel = cfg_we && (cfg_tile == TILE_SEL_W'(t));

        strmatch_tile #(
            .STATE_W (STATE_W),
            .PMV_W   (PMV_W),
            .ROW_W   (ROW_W)
        ) u_tile (
            .clk        (clk),
            .rst_n      (rst_n),
            .field_i    (byte_data[t*FIELD_W +: FIELD_W]),
            .in_valid_i (byte_valid),
            .restart_i  (pkt_restart),
            .wr_en_i    (wr_sel),
            .wr_addr_i  (cfg_addr),
            .wr_row_i   (cfg_row),
            .pmv_o      (pmv_all[t])
        );
    end

    strmatch_and_stage #(
        .PMV_W (PMV_W)
    ) u_and (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid_i    (byte_valid),
        .pmv_i         (pmv_all),
        .match_valid_o (match_valid),
        .match_vec_o   (match_vec)
    );

    // R4: fixed two-cycle latency from byte to result
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> ##1 match_valid);

    // R4: vector is quiet whenever it is not valid
    assert_quiet_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> (match_vec == '0));
endmodule

// File: tb/strmatch_rule_module_test.sv
module strmatch_rule_module_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        pkt_restart = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_tile = '0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_row = '0;
    logic        match_valid;
    logic [15:0] match_vec;

    strmatch_rule_module uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .pkt_restart(pkt_restart), .cfg_we(cfg_we), .cfg_tile(cfg_tile),
        .cfg_addr(cfg_addr), .cfg_row(cfg_row),
        .match_valid(match_valid), .match_vec(match_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mtbl [4][16];
    logic [3:0]  mst [4];
    logic        pv [2];
    logic [15:0] pm [2];
    string       ptag [2];

    function automatic logic [31:0] row_of(int t, int s, logic [15:0] pmv);
        logic [31:0] r;
        r[15:0] = pmv;
        for (int f = 0; f < 4; f++) r[16+4*f +: 4] = 4'((s*5 + f*3 + t + 1) & 15);
        return r;
    endfunction

    function automatic logic [15:0] dense_pmv(int t, int s);
        logic [15:0] a, b;
        a = 16'h1 << ((s*7 + t*5) & 15);
        b = 16'h1 << ((s + t*3) & 15);
        return ~(a | b);
    endfunction

    function automatic logic [15:0] sparse_pmv(int t, int s);
        logic [31:0] x;
        int r;
        r = (s*3 + t) & 15;
        x = ({16'h0, 16'h0F3F} << r) | ({16'h0, 16'h0F3F} >> (16 - r));
        return x[15:0];
    endfunction

    task automatic step(input logic v, input logic [7:0] b, input logic rs,
                        input logic we, input logic [1:0] ts, input logic [3:0] a,
                        input logic [31:0] d, input string tag);
        logic [15:0] acc;
        logic [3:0]  base, nx;
        logic [1:0]  f;
        @(negedge clk);
        checks++;
        if (match_valid !== pv[1] || match_vec !== pm[1]) begin
            errors++;
            $display("FAIL %s: valid=%0b vec=%h expected valid=%0b vec=%h",
                     ptag[1], match_valid, match_vec, pv[1], pm[1]);
        end
        pv[1] = pv[0]; pm[1] = pm[0]; ptag[1] = ptag[0];
        acc = 16'hFFFF;
        for (int t = 0; t < 4; t++) begin
            base = rs ? 4'd0 : mst[t];
            if (v) begin
                f = b[2*t +: 2];
                nx = mtbl[t][base][16 + 4*f +: 4];
                acc &= mtbl[t][nx][15:0];
                mst[t] = nx;
            end else if (rs) begin
                mst[t] = 4'd0;
            end
        end
        pv[0] = v; pm[0] = v ? acc : 16'h0; ptag[0] = tag;
        if (we) mtbl[ts][a] = d;
        byte_valid = v; byte_data = b; pkt_restart = rs;
        cfg_we = we; cfg_tile = ts; cfg_addr = a; cfg_row = d;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 4'd0, 32'h0, tag);
    endtask

    task automatic load(input int t, input int s, input logic [31:0] d);
        step(1'b0, 8'h00, 1'b0, 1'b1, 2'(t), 4'(s), d, "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < 4; t++) begin
            mst[t] = 4'd0;
            for (int s = 0; s < 16; s++) mtbl[t][s] = 32'h0;
        end
        for (int i = 0; i < 2; i++) begin pv[i] = 1'b0; pm[i] = 16'h0; ptag[i] = "R8"; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state and empty tables
        repeat (3) idle("R8");
        for (int i = 0; i < 8; i++) step(1'b1, 8'(i*29 + 3), 1'b0, 1'b0, 2'd0, 4'd0, 32'h0, "R8");
        repeat (2) idle("R4");

        // R7: load dense tables
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 16; s++) load(t, s, row_of(t, s, dense_pmv(t, s)));

        // R1 R2 R3: full sweep of byte values in one stream
        step(1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 4'd0, 32'h0, "R6");
        for (int i = 0; i < 256; i++) step(1'b1, 8'(i), 1'b0, 1'b0, 2'd0, 4'd0, 32'h0, "R1");

        // R5 R6: gaps and restarts mixed in
        for (int i = 0; i < 120; i++)
            step((i % 3) != 0, 8'(i*37 + 11), (i % 11) == 0, 1'b0, 2'd0, 4'd0, 32'h0,
                 (i % 11) == 0 ? "R6" : "R5");

        // R7: writes landing during lookups
        for (int i = 0; i < 32; i++)
            step(1'b1, 8'(i*53 + 7), 1'b0, 1'b1, 2'(i % 4), 4'(i*3),
                 row_of(i % 4, (i*3) & 15, sparse_pmv(i % 4, i)), "R7");

        // R2: sparse tables, fresh sweep
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 16; s++) load(t, s, row_of(t, s, sparse_pmv(t, s)));
        step(1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 4'd0, 32'h0, "R6");
        for (int i = 0; i < 256; i++) step(1'b1, 8'(i*91 + 5), 1'b0, 1'b0, 2'd0, 4'd0, 32'h0, "R2");

        // R3: one tile alone flags every bit, others flag none
        for (int k = 0; k < 4; k++) begin
            for (int t = 0; t < 4; t++)
                for (int s = 0; s < 16; s++)
                    load(t, s, row_of(t, s, (t == k) ? 16'hFFFF : 16'h0));
            step(1'b1, 8'h5A, 1'b1, 1'b0, 2'd0, 4'd0, 32'h0, "R3");
            for (int i = 0; i < 24; i++) step(1'b1, 8'(i*17 + k), 1'b0, 1'b0, 2'd0, 4'd0, 32'h0, "R3");
        end
        // R3: all tiles flag everything
        for (int s = 0; s < 16; s++) load(1, s, row_of(1, s, 16'hFFFF));
        for (int s = 0; s < 16; s++) load(2, s, row_of(2, s, 16'hFFFF));
        for (int s = 0; s < 16; s++) load(0, s, row_of(0, s, 16'hFFFF));
        for (int i = 0; i < 8; i++) step(1'b1, 8'(i*13), 1'b0, 1'b0, 2'd0, 4'd0, 32'h0, "R3");

        repeat (3) idle("R4");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule